// File: doc/BRIEF.md
# Guarded Watchdog Control Register

This block holds the settings of a watchdog timer: a run bit and a three-bit prescaler select. Both go straight to an external watchdog counter. Software reaches them through one byte-wide register. A single-cycle write strobe carries a data byte, and a combinational read returns the current contents.

Software can switch the watchdog on at any moment. Switching it off is guarded by an unlock bit, and so is retuning the prescaler when the safety-level input is non-zero. Software first writes the unlock bit to one, which opens a short window of write cycles. A write in that window may clear the run bit or load a new prescaler value. The unlock bit then drops by itself when the window runs out. Oscillator, counting and reset generation belong to other blocks.

Register layout: bit 4 is the unlock bit, bit 3 is the run bit, bits 2..0 are the prescaler select, and bits 7..5 are unused.

Top module: `wdtCtrlReg`

## Requirements
- R1: After reset the register reads 0x00, `wdEnable` is 0 and `wdPrescale` is 0.
- R2: Bits 7..5 of `rdData` always read 0, whatever was written to them.
- R3: A write with bit 3 set makes `wdEnable` 1, in any safety level and whether or not the window is open.
- R4: A write with bit 3 clear, made while the unlock bit reads 0, leaves `wdEnable` unchanged.
- R5: A write with bit 4 set makes the unlock bit (`rdData[4]`) read 1 for exactly WINDOW_CYCLES (default 4) cycles after that write, then read 0. Writing 0 to bit 4 does not shorten the window.
- R6: A write with bit 3 clear, made while the unlock bit reads 1, clears `wdEnable`.
- R7: Writing bit 4 to one while the window is already open restarts the full window from that write.
- R8: With `safetyLevel` = 0, a write always loads bits 2..0 into `wdPrescale`.
- R9: With `safetyLevel` at 1, 2 or 3, a write loads bits 2..0 only while the unlock bit reads 1. Otherwise `wdPrescale` keeps its value.
- R10: When a write is refused for one field, the other fields of the same write still take effect.
- R11: An accepted write shows on `wdEnable`, `wdPrescale` and `rdData` at the first clock edge after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Current register contents |
| safetyLevel | input | 2 | 0 = prescaler unguarded; 1 to 3 = prescaler guarded |
| wdEnable | output | 1 | Run bit to the watchdog counter |
| wdPrescale | output | 3 | Prescaler select to the watchdog counter |

## Verification
The bench targets the window edges:
- A disable in the last window cycle must succeed, and one a cycle later must fail. A design with an off-by-one counter either keeps the watchdog running or lets it stop after the window closed.
- A second unlock while the window is open must restart it. A design that ignores the re-arm closes the window early and refuses a later disable.
- With the prescaler guarded, mixed writes check that a refused prescaler still lets the run bit update. A design that rejects the whole write loses the enable.
- Level 0 and level 1 traffic is compared against a behavioural model on every cycle. A design that guards the prescaler at level 0, or forgets the guard at level 1, shows a wrong `wdPrescale`.

// File: rtl/wdt_ctrl_pkg.sv
package wdt_ctrl_pkg;
  localparam int unsigned UnlockBit  = 4;
  localparam int unsigned RunBit     = 3;
  localparam int unsigned PrescaleW  = 3;
  localparam int unsigned RegW       = 8;

  typedef struct packed {
    logic setEnable;
    logic clearEnable;
    logic loadPrescale;
  } wdtStrobe_t;
endpackage

// File: rtl/wdtGuard.sv
module wdtGuard
  import wdt_ctrl_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [RegW-1:0]  wrData,
  input  logic [1:0]       safetyLevel,
  output wdtStrobe_t       strobe,
  output logic             changeOpen
);
  localparam int unsigned CntW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CntW-1:0] WinLoad = CntW'(WINDOW_CYCLES);

  logic [CntW-1:0] winCnt;
  logic            armWrite;

  assign armWrite   = wrEn && wrData[UnlockBit];
  assign changeOpen = (winCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)              winCnt <= '0;
    else if (armWrite)      winCnt <= WinLoad;
    else if (changeOpen)    winCnt <= winCnt - 1'b1;
  end

  always_comb begin
    strobe.setEnable    = wrEn && wrData[RunBit];
    strobe.clearEnable  = wrEn && !wrData[RunBit] && changeOpen;
    strobe.loadPrescale = wrEn && ((safetyLevel == 2'd0) || changeOpen);
  end

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    armWrite |=> (winCnt == WinLoad)); // R7
  AST_WINDOW_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!armWrite && changeOpen) |=> (winCnt == $past(winCnt) - 1'b1)); // R5
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WinLoad); // R5
endmodule

// File: rtl/wdtFields.sv
module wdtFields
  import wdt_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  wdtStrobe_t           strobe,
  input  logic [PrescaleW-1:0] newPrescale,
  output logic                 enable,
  output logic [PrescaleW-1:0] prescale
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      prescale <= '0;
    end else begin
      if (strobe.setEnable)        enable <= 1'b1;
      else if (strobe.clearEnable) enable <= 1'b0;
      if (strobe.loadPrescale)     prescale <= newPrescale;
    end
  end

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEnable |=> enable); // R3
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strobe.clearEnable) |=> enable); // R4
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPrescale |=> $stable(prescale)); // R9
  AST_PRESCALE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPrescale |=> (prescale == $past(newPrescale))); // R11
endmodule

// File: rtl/wdtCtrlReg.sv
module wdtCtrlReg
  import wdt_ctrl_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [1:0] safetyLevel,
  output logic       wdEnable,
  output logic [2:0] wdPrescale
);
  wdtStrobe_t strobe;
  logic       changeOpen;

  wdtGuard #(.WINDOW_CYCLES(WINDOW_CYCLES)) i_guard (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .safetyLevel (safetyLevel),
    .strobe      (strobe),
    .changeOpen  (changeOpen)
  );

  wdtFields i_fields (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .newPrescale (wrData[PrescaleW-1:0]),
    .enable      (wdEnable),
    .prescale    (wdPrescale)
  );

  assign rdData = {3'b000, changeOpen, wdEnable, wdPrescale};
endmodule

// File: tb/test_wdtCtrlReg.sv
module test_wdtCtrlReg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] safetyLevel = 2'd0;
  logic [7:0] rdData;
  logic       wdEnable;
  logic [2:0] wdPrescale;

  int checks = 0;
  int errors = 0;
  int mEn = 0;
  int mPre = 0;
  int mCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdtCtrlReg i_wdtCtrlReg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .safetyLevel(safetyLevel), .wdEnable(wdEnable), .wdPrescale(wdPrescale)
  );

  function automatic logic [7:0] modelRd();
    return {3'b000, (mCnt > 0) ? 1'b1 : 1'b0, mEn[0], mPre[2:0]};
  endfunction

  task automatic expect8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    expect8(tag, rdData, modelRd());
    expect8(tag, {7'd0, wdEnable}, {7'd0, mEn[0]});
    expect8(tag, {5'd0, wdPrescale}, {5'd0, mPre[2:0]});
  endtask

  task automatic step(bit we, logic [7:0] d, logic [1:0] lvl, string tag);
    bit open;
    wrEn = we; wrData = d; safetyLevel = lvl;
    @(posedge clk);
    open = (mCnt > 0);
    if (we) begin
      if (d[3]) mEn = 1;
      else if (open) mEn = 0;
      if (lvl == 2'd0 || open) mPre = d[2:0];
    end
    if (we && d[4]) mCnt = 4;
    else if (mCnt > 0) mCnt--;
    @(negedge clk);
    wrEn = 1'b0;
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
    step(1, 8'hE8, 0, "R2");                   // run bit set, upper bits dropped
    expect8("R3", {7'd0, wdEnable}, 8'd1);
    step(1, 8'h00, 0, "R4");                   // disable without unlock refused
    expect8("R4", {7'd0, wdEnable}, 8'd1);
    step(1, 8'h0D, 0, "R8");                   // level 0 prescale free
    expect8("R8", {5'd0, wdPrescale}, 8'd5);
    step(1, 8'h0A, 1, "R9");                   // level 1 locked
    expect8("R9", {5'd0, wdPrescale}, 8'd5);
    // R5: window length
    step(1, 8'h18, 1, "R5");
    for (int i = 0; i < 3; i++) begin
      step(0, 8'h00, 1, "R5");
      expect8("R5", {7'd0, rdData[4]}, 8'd1);
    end
    step(0, 8'h00, 1, "R5");
    expect8("R5", {7'd0, rdData[4]}, 8'd0);
    // R6/R11: disable in last window cycle
    step(1, 8'h18, 1, "R6");
    step(0, 8'h00, 1, "R6");
    step(0, 8'h00, 1, "R6");
    step(0, 8'h00, 1, "R6");
    step(1, 8'h02, 1, "R11");
    expect8("R6", {7'd0, wdEnable}, 8'd0);
    expect8("R11", {5'd0, wdPrescale}, 8'd2);
    // one cycle too late
    step(1, 8'h18, 1, "R4");
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, "R4");
    step(1, 8'h01, 1, "R4");
    expect8("R4", {7'd0, wdEnable}, 8'd1);
    // R7: re-arm extends window
    step(1, 8'h18, 1, "R7");
    step(0, 8'h00, 1, "R7");
    step(0, 8'h00, 1, "R7");
    step(1, 8'h18, 1, "R7");
    step(0, 8'h00, 1, "R7");
    step(0, 8'h00, 1, "R7");
    step(0, 8'h00, 1, "R7");
    step(1, 8'h03, 1, "R7");
    expect8("R7", {7'd0, wdEnable}, 8'd0);
    // R10: enable accepted while prescale refused
    for (int i = 0; i < 4; i++) step(0, 8'h00, 2, "R10");
    step(1, 8'h0F, 2, "R10");
    expect8("R10", {4'd0, wdEnable, wdPrescale}, 8'h0B);
    // random traffic against the model
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 2) != 0, 8'($urandom), 2'($urandom), "R11");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule